// File: doc/BRIEF.md
# Open-Row DRAM Access Sequencer

This block sits between a processor's external memory strobes and an asynchronous DRAM with a multiplexed address bus. It turns a memory select, a read or write strobe and a page-change hint into the row strobe, column strobe and write enable that the DRAM needs. It also drives a row/column select that steers either the upper or the lower half of the processor address onto the DRAM address pins. The processor waits until the acknowledge output rises for one cycle. The block has no buffering and no back-pressure path: the processor holds its strobes and address until it sees acknowledge.

After an access the row strobe stays low, so the row stays open. A later access to the same page needs only a column pulse. A page change, or the first access after the controller has been idle, opens a new row first. An external interval timer raises a refresh request. The block answers it with a column-before-row refresh and returns a one-cycle refresh-done pulse, which the timer uses to withdraw its request. An access and a refresh never interrupt each other. Whichever has started runs to its end before the other is taken.

Top module: `dram_page_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces the idle state at once from any state, with ras_n, cas_n and we_n high and ack, rfsh_done and row_sel low. These strobes do not move while reset is held, whatever the other inputs do.
- R2: In idle, a refresh request wins over a memory select that arrives in the same cycle. The access is served only after the refresh.
- R3: Refresh waveform, counted in cycles after the request is taken: two cycles with ras_n and cas_n high, then one cycle with cas_n low, then one cycle with both low, then three cycles with ras_n low and cas_n high. rfsh_done is high only in the last of those three cycles.
- R4: When a refresh ends, the controller opens a row if mem_sel is high. Otherwise it returns to idle, with all strobes high.
- R5: When row_sel is high, dram_addr carries addr[21:11]. When row_sel is low, dram_addr carries addr[10:0]. row_sel changes on the falling clock edge. It is high when ras_n falls for a row open, and low when cas_n falls for an access.
- R6: The first access after idle always opens a row, whatever page_chg says. Acknowledge is seen 7 cycles after the strobes are presented.
- R7: In the column cycle, a read gives cas_n low with we_n high, and a write gives cas_n low with we_n low. If a row has been opened and neither rd_req nor wr_req is high, the controller returns to idle without acknowledge.
- R8: ack is high for exactly one cycle, the cycle right after the cas_n-low cycle. In that cycle cas_n is high and ras_n stays low. At every other time ack is low.
- R9: While a row is open, the controller serves a refresh request first, then a select with page_chg high (a new row, 7 cycles to ack), then a same-page read or write (2 cycles to ack, ras_n stays low). With none of these it waits with ras_n low.
- R10: An access in progress finishes before a pending refresh starts. A select that arrives with a refresh, or during one, gets ack only after rfsh_done.
- R11: During an access, cas_n falls only while ras_n was already low in the previous cycle. rfsh_done is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_sel | input | 1 | Processor selects the DRAM bank |
| rd_req | input | 1 | Read strobe (takes priority over wr_req) |
| wr_req | input | 1 | Write strobe |
| page_chg | input | 1 | Access falls outside the open row |
| addr | input | 22 | Processor word address; [21:11] row, [10:0] column |
| rfsh_req | input | 1 | Refresh request from the interval timer |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| row_sel | output | 1 | High: row half on dram_addr (falling-edge register) |
| dram_addr | output | 11 | Multiplexed DRAM address |
| ack | output | 1 | One-cycle access completion to the processor |
| rfsh_done | output | 1 | One-cycle refresh completion to the timer |

## Verification
Accesses are tried from idle with page_chg low, and from an open row with page_chg both low and high. The cycle count to acknowledge tells a row open from a column-only access, and so shows that page_chg is ignored after idle. Refresh requests are placed alone in idle, together with a select in idle and in the open-row state, and one cycle into an access. Where refresh_done lands relative to ack shows which operation won and that neither was cut short. The row and column values captured on the DRAM address pins at each strobe edge, and the state of we_n, tell the mux phases and read from write apart.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_RF1   = 4'd1,
    ST_RF2   = 4'd2,
    ST_RF3   = 4'd3,
    ST_RF4   = 4'd4,
    ST_RF5   = 4'd5,
    ST_RF6   = 4'd6,
    ST_RF7   = 4'd7,
    ST_NR0   = 4'd8,
    ST_NR1   = 4'd9,
    ST_NR2   = 4'd10,
    ST_NR3   = 4'd11,
    ST_OPEN  = 4'd12,
    ST_WAIT  = 4'd13,
    ST_HOLD  = 4'd14,
    ST_DROP  = 4'd15
  } ctl_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic ack;
    logic done;
  } strobe_t;

  localparam strobe_t STROBE_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                       ack: 1'b0, done: 1'b0};

  function automatic logic in_row_phase(ctl_state_e s);
    return (s == ST_NR0) || (s == ST_NR1) || (s == ST_NR2) || (s == ST_NR3);
  endfunction

endpackage

// File: rtl/dpc_row_mux.sv
module dpc_row_mux #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_phase,
  input  logic [ADDR_W-1:0] addr,
  output logic              row_sel,
  output logic [COL_W-1:0]  dram_addr
);

  // Falling-edge register: select settles half a cycle before RAS moves.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) row_sel <= 1'b0;
    else        row_sel <= row_phase;
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < ROW_W) begin : g_mux
      assign dram_addr[i] = row_sel ? addr[COL_W + i] : addr[i];
    end else begin : g_colonly
      assign dram_addr[i] = row_sel ? 1'b0 : addr[i];
    end
  end

endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mem_sel,
  input  logic rd_req,
  input  logic wr_req,
  input  logic page_chg,
  input  logic rfsh_req,
  output logic row_phase,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ack,
  output logic rfsh_done
);

  ctl_state_e st_q, st_d;
  strobe_t    out_q, out_d;

  always_comb begin
    st_d  = st_q;
    out_d = STROBE_QUIET;
    unique case (st_q)
      ST_IDLE: begin
        if (rfsh_req)     st_d = ST_RF1;
        else if (mem_sel) st_d = ST_NR0;
      end
      ST_RF1: st_d = ST_RF2;
      ST_RF2: begin st_d = ST_RF3; out_d.cas_n = 1'b0; end
      ST_RF3: begin st_d = ST_RF4; out_d.cas_n = 1'b0; out_d.ras_n = 1'b0; end
      ST_RF4: begin st_d = ST_RF5; out_d.ras_n = 1'b0; end
      ST_RF5: begin st_d = ST_RF6; out_d.ras_n = 1'b0; end
      ST_RF6: begin st_d = ST_RF7; out_d.ras_n = 1'b0; out_d.done = 1'b1; end
      ST_RF7: st_d = mem_sel ? ST_NR0 : ST_IDLE;
      ST_NR0: st_d = ST_NR1;
      ST_NR1: st_d = ST_NR2;
      ST_NR2: begin st_d = ST_NR3;  out_d.ras_n = 1'b0; end
      ST_NR3: begin st_d = ST_OPEN; out_d.ras_n = 1'b0; end
      ST_OPEN: begin
        if (rd_req) begin
          st_d = ST_HOLD; out_d.ras_n = 1'b0; out_d.cas_n = 1'b0;
        end else if (wr_req) begin
          st_d = ST_HOLD; out_d.ras_n = 1'b0; out_d.cas_n = 1'b0; out_d.we_n = 1'b0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (rfsh_req) begin
          st_d = ST_RF1;
        end else if (mem_sel && page_chg) begin
          st_d = ST_NR0;
        end else if (mem_sel && rd_req) begin
          st_d = ST_HOLD; out_d.ras_n = 1'b0; out_d.cas_n = 1'b0;
        end else if (mem_sel && wr_req) begin
          st_d = ST_HOLD; out_d.ras_n = 1'b0; out_d.cas_n = 1'b0; out_d.we_n = 1'b0;
        end else begin
          out_d.ras_n = 1'b0;
        end
      end
      ST_HOLD: begin
        if (rd_req || wr_req) begin
          st_d = ST_DROP; out_d.ras_n = 1'b0; out_d.ack = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_DROP: begin st_d = ST_WAIT; out_d.ras_n = 1'b0; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      out_q <= STROBE_QUIET;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
    end
  end

  assign row_phase = in_row_phase(st_q);
  assign ras_n     = out_q.ras_n;
  assign cas_n     = out_q.cas_n;
  assign we_n      = out_q.we_n;
  assign ack       = out_q.ack;
  assign rfsh_done = out_q.done;

  assert_cas_after_ras_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> $past(!ras_n));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> !rfsh_done);
  assert_done_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |-> (!ras_n && cas_n && $past(!ras_n)));
  assert_ack_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_ack_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cas_n && !ras_n && $past(!cas_n)));
  assert_we_with_cas_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cas_n);

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_sel,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              page_chg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rfsh_req,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              row_sel,
  output logic [COL_W-1:0]  dram_addr,
  output logic              ack,
  output logic              rfsh_done
);

  logic row_phase;

  dpc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_sel   (mem_sel),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .page_chg  (page_chg),
    .rfsh_req  (rfsh_req),
    .row_phase (row_phase),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ack       (ack),
    .rfsh_done (rfsh_done)
  );

  dpc_row_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_phase (row_phase),
    .addr      (addr),
    .row_sel   (row_sel),
    .dram_addr (dram_addr)
  );

  // Row strobe falling with column strobe high is a row open: row half must be steered.
  assert_row_on_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> row_sel);
  // Column strobe falling under an open row must see the column half.
  assert_col_on_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> !row_sel);

endmodule

// File: tb/dram_page_ctrl_tb_top.sv
module dram_page_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        mem_sel = 1'b0, rd_req = 1'b0, wr_req = 1'b0, page_chg = 1'b0;
  logic [21:0] addr = '0;
  logic        rfsh_req = 1'b0;
  logic        ras_n, cas_n, we_n, row_sel, ack, rfsh_done;
  logic [10:0] dram_addr;

  int n_checks = 0;
  int n_fail = 0;
  int viol_cas = 0;
  int viol_done = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_done = 1'b0;

  dram_page_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .rd_req(rd_req), .wr_req(wr_req),
    .page_chg(page_chg), .addr(addr), .rfsh_req(rfsh_req), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .row_sel(row_sel), .dram_addr(dram_addr),
    .ack(ack), .rfsh_done(rfsh_done)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to just after the next rising edge; timer model drops request on done.
  task automatic tick();
    @(posedge clk);
    #1;
    if (!cas_n && prev_cas && !ras_n && prev_ras) viol_cas++;
    if (rfsh_done && prev_done) viol_done++;
    if (rfsh_done) rfsh_req = 1'b0;
    prev_ras = ras_n; prev_cas = cas_n; prev_done = rfsh_done;
  endtask

  task automatic idle_inputs();
    mem_sel = 0; rd_req = 0; wr_req = 0; page_chg = 0;
  endtask

  task automatic t_reset();
    int bad = 0;
    rst_n = 1'b0;
    mem_sel = 1; rd_req = 1; rfsh_req = 1; page_chg = 1;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (!(ras_n && cas_n && we_n && !ack && !rfsh_done && !row_sel)) bad++;
      rd_req = ~rd_req; rfsh_req = ~rfsh_req;
    end
    chk(bad == 0, "R1 strobes quiet in reset", bad, 0);
    idle_inputs(); rfsh_req = 0;
    rst_n = 1'b1;
    tick();
    chk(ras_n && cas_n && we_n && !ack, "R1 idle after reset", {ras_n, cas_n, we_n, ack}, 4'b1110);
  endtask

  task automatic t_refresh_idle();
    logic [7:0] e_ras = 8'b10000111;
    logic [7:0] e_cas = 8'b11110011;
    logic [7:0] e_done = 8'b01000000;
    rfsh_req = 1;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(ras_n == e_ras[i] && cas_n == e_cas[i] && rfsh_done == e_done[i],
          $sformatf("R3 refresh step %0d", i + 1),
          {ras_n, cas_n, rfsh_done}, {e_ras[i], e_cas[i], e_done[i]});
    end
    chk(ras_n && cas_n && rfsh_req == 0, "R4 idle after refresh", {ras_n, cas_n}, 3);
  endtask

  task automatic do_access(input bit is_wr, input bit pg, input logic [21:0] a,
                           input bit with_rfq, input int exp_lat, input bit new_row,
                           input string req);
    int lat = 0;
    bit got = 0, row_got = 0, col_got = 0, ras_rose = 0, done_seen = 0;
    logic [10:0] row_cap = '0, col_cap = '0;
    logic we_cap = 1'b1, lr, lc;
    lr = ras_n; lc = cas_n;
    mem_sel = 1; rd_req = !is_wr; wr_req = is_wr; page_chg = pg; addr = a;
    if (with_rfq) rfsh_req = 1;
    while (!got && lat < 40) begin
      tick();
      lat++;
      if (rfsh_done) done_seen = 1;
      if (lr && !ras_n && cas_n) begin row_cap = dram_addr; row_got = 1; end
      if (!lr && ras_n) ras_rose = 1;
      if (lc && !cas_n && !ras_n) begin col_cap = dram_addr; col_got = 1; we_cap = we_n; end
      if (ack) got = 1;
      lr = ras_n; lc = cas_n;
    end
    chk(lat == exp_lat, {req, " cycles to ack"}, lat, exp_lat);
    chk(cas_n && !ras_n, "R8 ack cycle strobe state", {ras_n, cas_n}, 1);
    idle_inputs();
    tick();
    chk(!ack, "R8 ack lasts one cycle", ack, 0);
    chk(col_got && col_cap == a[10:0], "R5 column on cas fall", col_cap, a[10:0]);
    chk(we_cap == !is_wr, "R7 we_n during cas", we_cap, !is_wr);
    if (new_row) chk(row_got && row_cap == a[21:11], "R5 row on ras fall", row_cap, a[21:11]);
    else         chk(!ras_rose, "R9 row kept open", ras_rose, 0);
    if (with_rfq) chk(done_seen, "R10 refresh done before ack", done_seen, 1);
  endtask

  task automatic t_refresh_during_access();
    int lat = 0;
    bit done_at = 0;
    mem_sel = 1; rd_req = 1; page_chg = 0; addr = 22'h0155AA;
    tick();
    rfsh_req = 1;
    tick();
    chk(ack, "R10 access completes before refresh", ack, 1);
    idle_inputs();
    tick();
    chk(!ras_n && !ack, "R10 row open until refresh starts", ras_n, 0);
    lat = 3;
    while (!done_at && lat < 20) begin
      tick(); lat++;
      if (rfsh_done) done_at = 1;
    end
    chk(lat == 10, "R10 refresh follows access", lat, 10);
    tick();
    chk(ras_n && cas_n, "R4 idle after refresh with no select", {ras_n, cas_n}, 3);
  endtask

  task automatic t_open_no_strobe();
    int acks = 0;
    bit ras_low5;
    mem_sel = 1; rd_req = 0; wr_req = 0; page_chg = 0; addr = 22'h2AAAAA;
    for (int i = 1; i <= 6; i++) begin
      tick();
      if (ack) acks++;
      if (i == 5) ras_low5 = !ras_n;
    end
    chk(ras_low5, "R7 row opened before abandon", ras_low5, 1);
    chk(ras_n && cas_n, "R7 returns idle with no strobe", {ras_n, cas_n}, 3);
    idle_inputs();
    tick(); if (ack) acks++;
    tick(); if (ack) acks++;
    chk(acks == 0, "R7 no ack without strobe", acks, 0);
  endtask

  task automatic t_reset_mid_refresh();
    rfsh_req = 1;
    for (int i = 0; i < 4; i++) tick();
    chk(!ras_n && !cas_n, "R3 inside refresh before reset", {ras_n, cas_n}, 0);
    rst_n = 0;
    #1;
    chk(ras_n && cas_n && we_n && !ack && !rfsh_done, "R1 async reset mid refresh",
        {ras_n, cas_n, we_n}, 7);
    rfsh_req = 0;
    tick(); tick();
    rst_n = 1;
    tick();
    chk(ras_n && cas_n, "R1 idle after reset release", {ras_n, cas_n}, 3);
  endtask

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_refresh_idle();
    // R6: first access after idle opens a row even with page_chg low
    do_access(0, 0, 22'h1ABC5D, 0, 7, 1, "R6 first read after idle");
    do_access(1, 0, 22'h1ABC12, 0, 2, 0, "R9 same-page write");
    do_access(0, 0, 22'h1ABC7F, 0, 2, 0, "R9 same-page read");
    do_access(0, 1, 22'h0F0F33, 0, 7, 1, "R9 page change read");
    t_refresh_during_access();
    // R2: refresh and select together in idle; refresh first, then row open (R4)
    do_access(1, 1, 22'h3C3A55, 1, 14, 1, "R2 idle refresh wins");
    // R9: refresh wins over same-page access in the open-row wait
    do_access(0, 0, 22'h3C3B01, 1, 14, 1, "R9 wait refresh wins");
    rfsh_req = 1;
    for (int i = 0; i < 8; i++) tick();
    chk(ras_n && cas_n, "R4 open row refresh returns idle", {ras_n, cas_n}, 3);
    t_open_no_strobe();
    t_reset_mid_refresh();
    chk(viol_cas == 0, "R11 cas falls only under open row", viol_cas, 0);
    chk(viol_done == 0, "R11 refresh done single cycle", viol_done, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule